// File: doc/BRIEF.md
# Asymmetric Saturating Sample Mixer

This block folds a burst of voice amplitudes into one audio sample per sample period. A ready strobe marks the boundary of each period. Between strobes, every amplitude offered with its valid strobe is added into a running 16-bit accumulator. The amplitudes are two's-complement numbers carried in plain unsigned vectors: a value above 0x7FFF counts as negative. The sum clamps on positive overflow only. When both the running sum and the incoming value are non-negative and their total would pass 0x7FFF, the sum pins at 0x7FFF. Any addition that involves a negative operand wraps modulo 2^16.

On each ready strobe, the completed sum moves into the output register and the accumulator starts a fresh period. In playback mode, the output register loads the stored sample presented on that strobe instead of the sum. A second output carries the same sample widened to 20 bits with four zero bits below it, ready for a codec slot.

The amplitude input has no back-pressure. It has a valid strobe and no ready return, so the block accepts every value in the cycle its valid is high. Upstream logic must present each amplitude for exactly one valid cycle. A value held valid for two cycles is counted twice.

Top module: `sample_mixer`

## Requirements
- R1: While reset is asserted, the sample output and the slot output are zero. They stay zero until the first ready strobe.
- R2: In mix mode (playback flag low), a ready strobe loads the accumulated sum into the sample output. The sample output then holds its value until the next ready strobe.
- R3: A ready strobe clears the accumulator, so a period with no valid amplitudes produces a sample of 0x0000.
- R4: When the running sum and the incoming value both have bit 15 clear and their total exceeds 0x7FFF, the sum becomes exactly 0x7FFF.
- R5: When either the running sum or the incoming value has bit 15 set, the new sum is their total modulo 2^16 (for example, 0x8000 + 0x8000 gives 0x0000).
- R6: An amplitude presented while the valid strobe is low has no effect on any later sample.
- R7: When the ready strobe and a valid amplitude arrive in the same cycle, the output takes the completed sum without that value. The value becomes the first term of the new period.
- R8: When the playback flag is high at a ready strobe, the sample output loads the stored sample present in that cycle. The accumulator sum is discarded.
- R9: The slot output always equals the sample output in bits 19:4, with bits 3:0 at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | Sample-period boundary strobe |
| amp_valid | input | 1 | Amplitude valid strobe, accepted every cycle it is high |
| amp_in | input | 16 | Two's-complement voice amplitude |
| playback_en | input | 1 | Selects the stored sample as the output source |
| stored_in | input | 16 | Stored sample for playback |
| sample_out | output | 16 | Registered mixed or played-back sample |
| slot_out | output | 20 | Sample zero-padded in the low four bits |

## Verification
The bench aims at the clamp edge. For example, 0x7000 + 0x1000 must stop at 0x7FFF. A design that clamps on any carry, or that clamps negative sums as well, would instead produce 0x8000 or a pinned negative value. Sums of two negatives such as 0x8000 + 0x8000 must wrap to zero, which catches a symmetric saturator. Coincident ready and valid checks that the value lands in the next sample and is neither lost nor added to the old one. Playback, empty periods and valid-low amplitudes are also exercised. A bypass that leaked the sum, a missing clear, or a missing valid gate would each show up as a wrong sample at the port. Hundreds of random periods mixing positive and negative amplitudes are compared against a bench model.

// File: rtl/mix_pkg.sv
package mix_pkg;
  typedef enum logic {
    SRC_MIX    = 1'b0,
    SRC_STORED = 1'b1
  } out_src_e;
endpackage

// File: rtl/mix_sat_add.sv
module mix_sat_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         clamped
);
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] wrap_sum;
  logic         both_pos;

  always_comb begin
    wrap_sum = a + b;
    both_pos = ~a[W-1] & ~b[W-1];
    clamped  = both_pos & wrap_sum[W-1];
    y        = clamped ? POS_MAX : wrap_sum;
  end
endmodule

// File: rtl/mix_accum.sv
module mix_accum #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         valid,
  input  logic [W-1:0] amp,
  output logic [W-1:0] acc
);
  logic [W-1:0] sum_next;
  logic         sat_hit;

  mix_sat_add #(.W(W)) u_add (
    .a       (acc),
    .b       (amp),
    .y       (sum_next),
    .clamped (sat_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (tick) begin
      acc <= valid ? amp : '0;
    end else if (valid) begin
      acc <= sum_next;
    end
  end
endmodule

// File: rtl/mix_out_stage.sv
module mix_out_stage
  import mix_pkg::*;
#(
  parameter int W   = 16,
  parameter int PAD = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  out_src_e       src,
  input  logic [W-1:0]   mix_sum,
  input  logic [W-1:0]   stored,
  output logic [W-1:0]   sample,
  output logic [W+PAD-1:0] slot
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample <= '0;
    end else if (tick) begin
      sample <= (src == SRC_STORED) ? stored : mix_sum;
    end
  end

  generate
    if (PAD > 0) begin : g_pad
      assign slot = {sample, {PAD{1'b0}}};
    end else begin : g_nopad
      assign slot = sample;
    end
  endgenerate
endmodule

// File: rtl/sample_mixer.sv
module sample_mixer
  import mix_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SLOT_W   = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_tick,
  input  logic                amp_valid,
  input  logic [SAMPLE_W-1:0] amp_in,
  input  logic                playback_en,
  input  logic [SAMPLE_W-1:0] stored_in,
  output logic [SAMPLE_W-1:0] sample_out,
  output logic [SLOT_W-1:0]   slot_out
);
  localparam int PAD_W = SLOT_W - SAMPLE_W;

  logic [SAMPLE_W-1:0] acc_q;
  out_src_e            src_sel;

  assign src_sel = playback_en ? SRC_STORED : SRC_MIX;

  mix_accum #(.W(SAMPLE_W)) u_accum (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (frame_tick),
    .valid (amp_valid),
    .amp   (amp_in),
    .acc   (acc_q)
  );

  mix_out_stage #(.W(SAMPLE_W), .PAD(PAD_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (frame_tick),
    .src     (src_sel),
    .mix_sum (acc_q),
    .stored  (stored_in),
    .sample  (sample_out),
    .slot    (slot_out)
  );
endmodule

// File: rtl/sample_mixer_chk.sv
module sample_mixer_chk #(
  parameter int W = 16,
  parameter int S = 20
) (
  input logic         clk,
  input logic         rst_n,
  input logic         frame_tick,
  input logic         amp_valid,
  input logic [W-1:0] amp_in,
  input logic         playback_en,
  input logic [W-1:0] stored_in,
  input logic [W-1:0] sample_out,
  input logic [S-1:0] slot_out,
  input logic [W-1:0] acc
);
  assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_tick && $past(rst_n)) |=> $stable(sample_out));

  assert_mix_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !playback_en) |=> (sample_out == $past(acc)));

  assert_clear_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !amp_valid) |=> (acc == '0));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_valid && !frame_tick && !acc[W-1] && !amp_in[W-1]) |=> !acc[W-1]);

  assert_ignore_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!amp_valid && !frame_tick) |=> $stable(acc));

  assert_coincident_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && amp_valid) |=> (acc == $past(amp_in)));

  assert_playback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && playback_en) |=> (sample_out == $past(stored_in)));

  assert_slot_pad_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_out[S-1:S-W] == sample_out) && (slot_out[S-W-1:0] == '0));
endmodule

bind sample_mixer sample_mixer_chk #(.W(SAMPLE_W), .S(SLOT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_tick  (frame_tick),
  .amp_valid   (amp_valid),
  .amp_in      (amp_in),
  .playback_en (playback_en),
  .stored_in   (stored_in),
  .sample_out  (sample_out),
  .slot_out    (slot_out),
  .acc         (acc_q)
);

// File: tb/sample_mixer_test.sv
module sample_mixer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_tick = 1'b0;
  logic        amp_valid = 1'b0;
  logic [15:0] amp_in = '0;
  logic        playback_en = 1'b0;
  logic [15:0] stored_in = '0;
  logic [15:0] sample_out;
  logic [19:0] slot_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  logic [15:0] m_acc = '0;
  logic [15:0] m_out = '0;

  always #4 clk = ~clk;

  sample_mixer uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_tick  (frame_tick),
    .amp_valid   (amp_valid),
    .amp_in      (amp_in),
    .playback_en (playback_en),
    .stored_in   (stored_in),
    .sample_out  (sample_out),
    .slot_out    (slot_out)
  );

  function automatic logic [15:0] ref_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] t;
    t = {1'b0, a} + {1'b0, b};
    if (!a[15] && !b[15] && t > 17'h07FFF) return 16'h7FFF;
    return t[15:0];
  endfunction

  task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check20(input string req, input logic [19:0] act, input logic [19:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One clock: drive on the falling edge, update model at the rising edge, check after it.
  task automatic step(input bit tk, input bit vl, input logic [15:0] a,
                      input bit pb, input logic [15:0] st, input string req);
    @(negedge clk);
    frame_tick = tk; amp_valid = vl; amp_in = a; playback_en = pb; stored_in = st;
    @(posedge clk);
    if (tk) begin
      m_out = pb ? st : m_acc;
      m_acc = vl ? a : 16'h0000;
    end else if (vl) begin
      m_acc = ref_add(m_acc, a);
    end
    #1;
    check16(req, sample_out, m_out);
    check20("R9", slot_out, {m_out, 4'h0});
  endtask

  task automatic add(input logic [15:0] a);
    step(0, 1, a, 0, 16'h0, "R2");
  endtask

  task automatic tick_mix(input string req);
    step(1, 0, 16'h0, 0, 16'h0, req);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check16("R1", sample_out, 16'h0000);
    check20("R1", slot_out, 20'h00000);
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 16'h0, 0, 16'h0, "R1");

    // R3: empty period gives zero
    tick_mix("R3");
    tick_mix("R3");

    // R2: simple sum
    add(16'h0100); add(16'h0023); add(16'hFFFF);
    tick_mix("R2");
    check16("R2", sample_out, 16'h0122);
    step(0, 0, 16'h0, 0, 16'h0, "R2");

    // R4: positive clamp, then a negative pulls it down
    add(16'h7000); add(16'h1000);
    tick_mix("R4");
    check16("R4", sample_out, 16'h7FFF);
    add(16'h7000); add(16'h1000); add(16'hFFFF);
    tick_mix("R4");
    check16("R4", sample_out, 16'h7FFE);
    add(16'h7FFF); add(16'h0001);
    tick_mix("R4");
    check16("R4", sample_out, 16'h7FFF);

    // R5: negative wraps
    add(16'h8000); add(16'h8000);
    tick_mix("R5");
    check16("R5", sample_out, 16'h0000);
    add(16'hC000); add(16'h7000);
    tick_mix("R5");
    check16("R5", sample_out, 16'h3000);

    // R6: invalid amplitudes ignored
    add(16'h0010);
    step(0, 0, 16'h5555, 0, 16'h0, "R6");
    step(0, 0, 16'h7FFF, 0, 16'h0, "R6");
    tick_mix("R6");
    check16("R6", sample_out, 16'h0010);

    // R7: coincident tick and valid
    add(16'h0200);
    step(1, 1, 16'h0033, 0, 16'h0, "R7");
    check16("R7", sample_out, 16'h0200);
    tick_mix("R7");
    check16("R7", sample_out, 16'h0033);

    // R8: playback bypass
    add(16'h1234);
    step(1, 0, 16'h0, 1, 16'hBEEF, "R8");
    check16("R8", sample_out, 16'hBEEF);
    step(0, 0, 16'h0, 1, 16'h1111, "R8");
    tick_mix("R8");
    check16("R8", sample_out, 16'h0000);

    // Random periods
    for (int p = 0; p < 400; p++) begin
      int n;
      n = $urandom_range(0, 6);
      for (int k = 0; k < n; k++) begin
        logic [15:0] a;
        case ($urandom_range(0, 3))
          0: a = 16'($urandom_range(0, 16'h7FFF));
          1: a = 16'($urandom_range(16'h8000, 16'hFFFF));
          2: a = 16'($urandom_range(16'h3000, 16'h7FFF));
          default: a = 16'($urandom);
        endcase
        step(0, ($urandom_range(0, 5) != 0), a, 0, 16'h0, "R4/R5");
      end
      step(1, ($urandom_range(0, 4) == 0), 16'($urandom), ($urandom_range(0, 5) == 0),
           16'($urandom), "R2");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule